// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Frequency Divider

This block is the feedback divider of an integer-N frequency synthesizer. It runs on the oscillator signal itself, which serves as its clock. Once per complete division cycle it emits a pulse, `fp`, one clock wide. In normal operation a prescaler divides by either ten or eleven. A 9-bit main counter counts prescaler periods. A 4-bit swallow counter holds the prescaler in its divide-by-eleven setting for the first few periods of each cycle. The total ratio from clock to `fp` is 10×(M+1)+A.

When the bypass control is high, the prescaler and the swallow counter are idle, and the main counter divides the clock by M+1 directly. New values of M, A and bypass are taken in only at the boundary between division cycles, so every cycle has the exact length of a single setting. A combinational error flag reports a setting whose swallow count exceeds the number of prescaler periods in a cycle.

Top module: `psw_divider`

## Requirements
- R1: With `bypass` low and A ≤ M+1, consecutive `fp` pulses are exactly 10×(M+1)+A clock cycles apart.
- R2: With `bypass` high, consecutive `fp` pulses are exactly M+1 clock cycles apart, whatever the value on `div_a`, including values above M+1.
- R3: When the active ratio is 2 or more, `fp` stays high for exactly one clock cycle per division cycle.
- R4: While `rst` is high (sampled on the rising edge), `fp` is low and all counters clear. The setting present at the last reset edge becomes active. Counting the first rising edge with `rst` low as edge 1, `fp` is first high in the cycle after edge N, where N is the active ratio.
- R5: A change of `div_m`, `div_a` or `bypass` during a division cycle leaves the length of that cycle unchanged. The new setting governs the next cycle, starting at the edge that raises `fp`.
- R6: `cfg_err` is high in the same cycle exactly when `bypass` is low and `div_a` > `div_m`+1, and low otherwise.
- R7: Boundary ratios: M=1 with bypass gives 2. M=1, A=0 without bypass gives 20. A=M+1 gives 11×(M+1). M=511, A=15 gives 5135.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator input, used as the divider clock |
| rst | input | 1 | Synchronous active-high reset |
| div_m | input | 9 | Main counter setting M (ratio M+1 prescaler periods) |
| div_a | input | 4 | Swallow count A (prescaler periods at divide-by-eleven) |
| bypass | input | 1 | High: skip the prescaler, divide by M+1 |
| fp | output | 1 | One-cycle pulse at the end of each division cycle |
| cfg_err | output | 1 | Combinational flag for A > M+1 with bypass low |

## Verification
The `fp` pulse is registered, so it rises in the cycle after the N-th counted edge. The bench drives inputs and releases reset on falling edges, then counts falling edges up to the one where `fp` is first seen high, which makes the expected count equal to N itself. The one-cycle width is checked at the very next falling edge, and that edge is counted as the first edge of the following period. `cfg_err` has no register in its path, so it is sampled shortly after the inputs change, with no clock edge in between. For mid-cycle changes, the bench keeps counting from the previous pulse through the change, and expects the old ratio once and the new ratio after it.

// File: rtl/psw_pkg.sv
package psw_pkg;
    parameter int M_W     = 9;
    parameter int A_W     = 4;
    parameter int PRE_LO  = 10;
    parameter int PRE_HI  = PRE_LO + 1;
    parameter int PRE_W   = $clog2(PRE_HI);
    parameter int RATIO_W = $clog2(PRE_HI * (2 ** M_W) + 1);

    // setting as presented on the ports
    typedef struct packed {
        logic           byp;
        logic [M_W-1:0] m;
        logic [A_W-1:0] a;
    } psw_cfg_t;

    // setting held for the cycle in progress (swallow count lives in its counter)
    typedef struct packed {
        logic           byp;
        logic [M_W-1:0] m;
    } psw_act_t;

    function automatic logic [RATIO_W-1:0] psw_ratio(input psw_cfg_t c);
        int r;
        if (c.byp) r = int'(c.m) + 1;
        else       r = PRE_LO * (int'(c.m) + 1) + int'(c.a);
        return RATIO_W'(r);
    endfunction

    function automatic logic psw_cfg_bad(input psw_cfg_t c);
        return !c.byp && (int'(c.a) > int'(c.m) + 1);
    endfunction
endpackage

// File: rtl/psw_prescaler.sv
module psw_prescaler
    import psw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bypass,
    input  logic swallow,
    output logic tick
);
    logic [PRE_W-1:0] pcnt;
    logic [PRE_W-1:0] last;

    always_comb begin
        last = swallow ? PRE_W'(PRE_HI - 1) : PRE_W'(PRE_LO - 1);
    end

    assign tick = bypass | (pcnt == last);

    always_ff @(posedge clk) begin
        if (rst || bypass || tick) pcnt <= '0;
        else                       pcnt <= pcnt + 1'b1;
    end
endmodule

// File: rtl/psw_counters.sv
module psw_counters
    import psw_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           tick,
    input  logic [M_W-1:0] act_m,
    input  logic [A_W-1:0] nxt_a,
    output logic           swallow,
    output logic           wrap
);
    logic [M_W-1:0] mcnt;
    logic [A_W-1:0] acnt;

    assign wrap    = tick && (mcnt == act_m);
    assign swallow = (acnt != '0);

    always_ff @(posedge clk) begin
        if (rst)       mcnt <= '0;
        else if (wrap) mcnt <= '0;
        else if (tick) mcnt <= mcnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || wrap)         acnt <= nxt_a;
        else if (tick && swallow) acnt <= acnt - 1'b1;
    end
endmodule

// File: rtl/psw_divider.sv
module psw_divider
    import psw_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [M_W-1:0] div_m,
    input  logic [A_W-1:0] div_a,
    input  logic           bypass,
    output logic           fp,
    output logic           cfg_err
);
    psw_cfg_t cfg_in;
    psw_act_t act_q;
    logic     tick;
    logic     swallow;
    logic     wrap;
    logic     fp_q;

    assign cfg_in  = '{byp: bypass, m: div_m, a: div_a};
    assign cfg_err = psw_cfg_bad(cfg_in);

    // setting is taken in only at reset or at a cycle boundary
    always_ff @(posedge clk) begin
        if (rst || wrap) act_q <= '{byp: cfg_in.byp, m: cfg_in.m};
    end

    always_ff @(posedge clk) begin
        if (rst) fp_q <= 1'b0;
        else     fp_q <= wrap;
    end

    assign fp = fp_q;

    psw_prescaler u_pre (
        .clk     (clk),
        .rst     (rst),
        .bypass  (act_q.byp),
        .swallow (swallow),
        .tick    (tick)
    );

    psw_counters u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .act_m   (act_q.m),
        .nxt_a   (cfg_in.a),
        .swallow (swallow),
        .wrap    (wrap)
    );
endmodule

// File: rtl/psw_divider_chk.sv
module psw_divider_chk
    import psw_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic [M_W-1:0] div_m,
    input logic [A_W-1:0] div_a,
    input logic           bypass,
    input logic           fp,
    input logic           cfg_err
);
    psw_cfg_t            cur_in;
    psw_cfg_t            last_in;
    logic [RATIO_W-1:0]  exp_r;
    logic [RATIO_W-1:0]  cnt;
    logic                exp_ok;

    assign cur_in = '{byp: bypass, m: div_m, a: div_a};

    always_ff @(posedge clk) begin
        last_in <= cur_in;
        if (rst) begin
            cnt    <= '0;
            exp_r  <= psw_ratio(cur_in);
            exp_ok <= !psw_cfg_bad(cur_in);
        end else if (fp) begin
            cnt    <= RATIO_W'(1);
            exp_r  <= psw_ratio(last_in);
            exp_ok <= !psw_cfg_bad(last_in);
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R1, R2, R5: spacing of pulses matches the setting active for that cycle
    p_period_r1: assert property (@(posedge clk) disable iff (rst)
        (fp && exp_ok) |-> (cnt == exp_r));

    // R4: no pulse before the full ratio has elapsed
    p_no_early_r4: assert property (@(posedge clk) disable iff (rst)
        (!fp && exp_ok) |-> (cnt < exp_r));

    // R3: single-cycle pulse for ratios of two or more
    p_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        (fp && (psw_ratio(last_in) > RATIO_W'(1))) |=> !fp);

    // R4: reset silences the output
    p_reset_quiet_r4: assert property (@(posedge clk)
        rst |=> !fp);

    // R6: bypass never flags an error
    p_err_bypass_r6: assert property (@(posedge clk) disable iff (rst)
        bypass |-> !cfg_err);
endmodule

bind psw_divider psw_divider_chk u_chk (.*);

// File: tb/tb_psw_divider.sv
module tb_psw_divider;
    import psw_pkg::*;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [M_W-1:0] div_m = '0;
    logic [A_W-1:0] div_a = '0;
    logic           bypass = 1'b0;
    logic           fp;
    logic           cfg_err;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    psw_divider dut (
        .clk     (clk),
        .rst     (rst),
        .div_m   (div_m),
        .div_a   (div_a),
        .bypass  (bypass),
        .fp      (fp),
        .cfg_err (cfg_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_in(input int m, input int a, input int b);
        div_m  = M_W'(m);
        div_a  = A_W'(a);
        bypass = b[0];
    endtask

    // counts falling edges from base until fp is seen high
    task automatic wait_fp(input int base, output int n);
        n = base;
        forever begin
            @(negedge clk);
            n++;
            if (fp || n > 6000) break;
        end
    endtask

    task automatic run_cfg(input int m, input int a, input int b, input string tag);
        int n;
        int exp_n;
        exp_n = b ? m + 1 : 10 * (m + 1) + a;
        @(negedge clk);
        rst = 1'b1;
        set_in(m, a, b);
        @(negedge clk);
        check(fp == 1'b0, "R4 fp low in reset", int'(fp), 0);
        @(negedge clk);
        rst = 1'b0;
        wait_fp(0, n);
        check(n == exp_n, "R4 first pulse after reset", n, exp_n);
        if (exp_n > 1) begin
            @(negedge clk);
            check(fp == 1'b0, "R3 pulse width", int'(fp), 0);
            wait_fp(1, n);
        end else begin
            wait_fp(0, n);
        end
        check(n == exp_n, tag, n, exp_n);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int n;
        // R6: combinational error flag sweep
        for (int b = 0; b < 2; b++)
            for (int m = 0; m < 20; m++)
                for (int a = 0; a < 16; a++) begin
                    set_in(m, a, b);
                    #1;
                    check(cfg_err == ((b == 0) && (a > m + 1)), "R6 cfg_err",
                          int'(cfg_err), int'((b == 0) && (a > m + 1)));
                end

        // R1: normal mode sweep over small M and every legal A
        for (int m = 1; m <= 12; m++)
            for (int a = 0; a <= m + 1 && a < 16; a++)
                run_cfg(m, a, 0, "R1 normal period");

        // R2: bypass sweep, with A values that must be ignored
        for (int m = 1; m <= 40; m++)
            run_cfg(m, (m * 7) % 16, 1, "R2 bypass period");

        // R7: boundaries
        run_cfg(1, 0, 1, "R7 bypass M=1");
        run_cfg(1, 0, 0, "R7 normal M=1 A=0");
        run_cfg(14, 15, 0, "R7 A=M+1");
        run_cfg(511, 15, 0, "R7 largest normal");
        run_cfg(511, 15, 1, "R7 largest bypass");

        // R5: changes in mid-cycle take effect only at the next boundary
        @(negedge clk);
        rst = 1'b1;
        set_in(3, 2, 0);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        wait_fp(0, n);
        check(n == 42, "R5 first period", n, 42);
        n = 0;
        repeat (5) begin @(negedge clk); n++; end
        set_in(6, 9, 1);
        wait_fp(n, n);
        check(n == 42, "R5 old period kept", n, 42);
        wait_fp(0, n);
        check(n == 7, "R5 new bypass period", n, 7);
        n = 0;
        repeat (3) begin @(negedge clk); n++; end
        set_in(1, 0, 0);
        wait_fp(n, n);
        check(n == 7, "R5 bypass period kept", n, 7);
        wait_fp(0, n);
        check(n == 20, "R5 new normal period", n, 20);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule